// File: doc/BRIEF.md
# Infrared Pulse-Train Capture Receiver

This block watches a demodulated infrared (or UHF) receiver line and turns each symbol into two numbers. The first is the mark time, the number of sampling ticks for which the line is active. The second is the symbol period, the ticks from one mark's leading edge to the next mark's leading edge. Each pair is written into a small receive queue. When the line stays inactive beyond a programmable limit, the train is closed with one last entry whose period is the all-ones sentinel 0xFFFF. The measurement then returns to idle.

Software sets the block up through a word-addressed register port: capture enable and input inversion, a tick divisor, the longest symbol period, and interrupt enables. It reads status and drains the queue through the same port. Reading the period register removes the head entry and keeps that entry's mark time in a separate register for a later read. A single interrupt line is the OR of the enabled status bits.

Register map (word address on `addr`): 0 control (bit 0 capture on, bit 1 invert input), 1 tick divisor, 2 maximum symbol period in ticks, 3 interrupt enable, 4 interrupt status (read), 5 interrupt clear (write), 6 receive status, 7 held mark time, 8 symbol period with pop. Interrupt bit layout, used by enable, status and clear: bit 0 data waiting, bit 1 last symbol seen, bit 2 overrun, bit 3 queue full.

Top module: `ir_capture_rx`

## Requirements
- R1: After reset the queue is empty, the receive status and the interrupt status read 0, and `irq` is low.
- R2: With one tick per cycle, a symbol of M active ticks followed by S inactive ticks is stored as mark M and period M+S when the next mark begins.
- R3: When, after a mark, the running period would exceed the maximum (address 2), an entry with the mark time and period 0xFFFF is stored, status bit 1 (last symbol) is set, and the next mark starts a fresh measurement.
- R4: With control bit 1 set, a low level on `ir_pin` is active. With it clear, a high level is active.
- R5: While control bit 0 is 0, no entry is stored, whatever the line does.
- R6: The divisor (address 1) makes one tick every D cycles, with 0 treated as 1. Mark and period are counted in ticks.
- R7: The queue holds 8 entries in arrival order. A read of address 8 returns the head period and pops it. Address 7 then returns that entry's mark time.
- R8: An entry that arrives while the queue holds 8 is dropped. Interrupt status bit 2 and receive status bit 2 are then set and stay set until cleared.
- R9: Interrupt status bit 0 is 1 when the queue is not empty. Bit 3 is 1 when it holds 8 entries. Receive status bits 15:8 give the occupancy.
- R10: Writing address 5 clears every sticky status bit (1 and 2) whose data bit is 1. Data bits that are 0 leave the status as it was.
- R11: `irq` is high exactly when some interrupt status bit and its enable bit (address 3) are both 1.
- R12: Mark and period counters saturate at 0xFFFF and never wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ir_pin | input | 1 | Demodulated receiver line, asynchronous |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (pops on address 8) |
| addr | input | 4 | Register word address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, combinational from `addr` |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that the divisor and the enable bit change only while the measurement is idle. They also assume that `rd_en` pulses last one cycle and that software never writes 0 to the maximum period while capture is on. The stimulus holds the configuration fixed during every train: it turns capture off before it changes the inversion, the divisor or the limit, and it returns the line to its idle level first. Random mark and space lengths are drawn well below the programmed maximum, so only the intended final gap can end a train. Every read is a single-cycle strobe.

// File: rtl/ir_capture_pkg.sv
package ir_capture_pkg;

    typedef enum logic [1:0] {
        MS_IDLE  = 2'd0,
        MS_MARK  = 2'd1,
        MS_SPACE = 2'd2
    } meas_state_e;

    localparam logic [3:0] A_CTRL   = 4'd0;
    localparam logic [3:0] A_DIV    = 4'd1;
    localparam logic [3:0] A_MAXSYM = 4'd2;
    localparam logic [3:0] A_IEN    = 4'd3;
    localparam logic [3:0] A_ISTAT  = 4'd4;
    localparam logic [3:0] A_ICLR   = 4'd5;
    localparam logic [3:0] A_RXSTAT = 4'd6;
    localparam logic [3:0] A_MARK   = 4'd7;
    localparam logic [3:0] A_SYM    = 4'd8;

    localparam int B_AVAIL = 0;
    localparam int B_LAST  = 1;
    localparam int B_OVR   = 2;
    localparam int B_FULL  = 3;

endpackage

// File: rtl/ir_tick_gen.sv
module ir_tick_gen #(
    parameter int DIVW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en_i,
    input  logic [DIVW-1:0] div_i,
    output logic            tick_o
);
    typedef struct packed {
        logic [DIVW-1:0] cnt;
        logic            tick;
    } tick_s;

    tick_s st_d, st_q;
    logic [DIVW-1:0] lim;

    always_comb begin
        st_d = st_q;
        lim  = (div_i == '0) ? '0 : div_i - 1'b1;
        if (!en_i) begin
            st_d.cnt  = '0;
            st_d.tick = 1'b0;
        end else if (st_q.cnt >= lim) begin
            st_d.cnt  = '0;
            st_d.tick = 1'b1;
        end else begin
            st_d.cnt  = st_q.cnt + 1'b1;
            st_d.tick = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tick_o = st_q.tick;

    AST_TICK_HALT: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !tick_o); // R5
    AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && en_i && div_i >= 2) |=> (!tick_o || div_i < 2 || !en_i)); // R6

endmodule

// File: rtl/ir_measure.sv
module ir_measure
    import ir_capture_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_i,
    input  logic          inv_i,
    input  logic          tick_i,
    input  logic          pin_i,
    input  logic [CW-1:0] max_i,
    output logic          push_o,
    output logic [CW-1:0] mark_o,
    output logic [CW-1:0] sym_o
);
    localparam logic [CW-1:0] SAT = '1;

    typedef struct packed {
        logic          sync1;
        logic          sync2;
        meas_state_e   st;
        logic [CW-1:0] mark;
        logic [CW-1:0] sym;
        logic          push;
        logic [CW-1:0] omark;
        logic [CW-1:0] osym;
    } meas_s;

    meas_s m_d, m_q;
    logic          act;
    logic [CW-1:0] mark_inc, sym_inc;

    always_comb begin
        m_d      = m_q;
        m_d.sync1 = pin_i;
        m_d.sync2 = m_q.sync1;
        m_d.push  = 1'b0;
        act       = m_q.sync2 ^ inv_i;
        mark_inc  = (m_q.mark == SAT) ? SAT : m_q.mark + 1'b1;
        sym_inc   = (m_q.sym == SAT) ? SAT : m_q.sym + 1'b1;
        if (!en_i) begin
            m_d.st   = MS_IDLE;
            m_d.mark = '0;
            m_d.sym  = '0;
        end else if (tick_i) begin
            case (m_q.st)
                MS_IDLE: begin
                    if (act) begin
                        m_d.st   = MS_MARK;
                        m_d.mark = 1;
                        m_d.sym  = 1;
                    end
                end
                MS_MARK: begin
                    m_d.sym = sym_inc;
                    if (act) m_d.mark = mark_inc;
                    else     m_d.st   = MS_SPACE;
                end
                MS_SPACE: begin
                    if (act) begin
                        m_d.push  = 1'b1;
                        m_d.omark = m_q.mark;
                        m_d.osym  = m_q.sym;
                        m_d.st    = MS_MARK;
                        m_d.mark  = 1;
                        m_d.sym   = 1;
                    end else if (sym_inc > max_i || m_q.sym == SAT) begin
                        m_d.push  = 1'b1;
                        m_d.omark = m_q.mark;
                        m_d.osym  = SAT;
                        m_d.st    = MS_IDLE;
                        m_d.mark  = '0;
                        m_d.sym   = '0;
                    end else begin
                        m_d.sym = sym_inc;
                    end
                end
                default: m_d.st = MS_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) m_q <= '0;
        else        m_q <= m_d;
    end

    assign push_o = m_q.push;
    assign mark_o = m_q.omark;
    assign sym_o  = m_q.osym;

    AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (m_q.st == MS_IDLE && !push_o)); // R5
    AST_MARK_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        push_o |-> (mark_o != '0 && sym_o >= mark_o)); // R2
    AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (m_q.mark == SAT && en_i) |=> (m_q.mark == SAT || m_q.mark <= 1)); // R12

endmodule

// File: rtl/ir_rx_fifo.sv
module ir_rx_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push_i,
    input  logic [W-1:0]                 wdata_i,
    input  logic                         pop_i,
    output logic [W-1:0]                 head_o,
    output logic [$clog2(DEPTH+1)-1:0]   count_o,
    output logic                         full_o,
    output logic                         empty_o
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNW = $clog2(DEPTH + 1);
    localparam logic [CNW-1:0] DEPTH_C = CNW'(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [AW-1:0]           wp;
        logic [AW-1:0]           rp;
        logic [CNW-1:0]          cnt;
    } fifo_s;

    fifo_s f_d, f_q;
    logic do_push, do_pop;

    function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        f_d     = f_q;
        do_push = push_i && (f_q.cnt != DEPTH_C);
        do_pop  = pop_i && (f_q.cnt != '0);
        if (do_push) begin
            f_d.mem[f_q.wp] = wdata_i;
            f_d.wp          = ptr_next(f_q.wp);
        end
        if (do_pop) f_d.rp = ptr_next(f_q.rp);
        if (do_push && !do_pop)      f_d.cnt = f_q.cnt + 1'b1;
        else if (do_pop && !do_push) f_d.cnt = f_q.cnt - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    assign head_o  = f_q.mem[f_q.rp];
    assign count_o = f_q.cnt;
    assign full_o  = (f_q.cnt == DEPTH_C);
    assign empty_o = (f_q.cnt == '0);

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        count_o <= DEPTH_C); // R7
    AST_DROP_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && full_o && !pop_i) |=> (count_o == DEPTH_C)); // R8

endmodule

// File: rtl/ir_capture_rx.sv
module ir_capture_rx
    import ir_capture_pkg::*;
#(
    parameter int CW    = 16,
    parameter int DIVW  = 16,
    parameter int DEPTH = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ir_pin,
    input  logic        wr_en,
    input  logic        rd_en,
    input  logic [3:0]  addr,
    input  logic [15:0] wdata,
    output logic [15:0] rdata,
    output logic        irq
);
    localparam int CNW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] SENT = '1;

    typedef struct packed {
        logic            en;
        logic            inv;
        logic [DIVW-1:0] div;
        logic [CW-1:0]   maxsym;
        logic [3:0]      ien;
        logic            last;
        logic            ovr;
        logic [CW-1:0]   mark_hold;
    } regs_s;

    regs_s r_d, r_q;

    logic            tick;
    logic            m_push;
    logic [CW-1:0]   m_mark, m_sym;
    logic [2*CW-1:0] head;
    logic [CNW-1:0]  count;
    logic            full, empty, pop;
    logic [3:0]      istat;
    logic            clr_wr;

    ir_tick_gen #(.DIVW(DIVW)) u_tick (
        .clk(clk), .rst_n(rst_n), .en_i(r_q.en), .div_i(r_q.div), .tick_o(tick)
    );

    ir_measure #(.CW(CW)) u_meas (
        .clk(clk), .rst_n(rst_n), .en_i(r_q.en), .inv_i(r_q.inv), .tick_i(tick),
        .pin_i(ir_pin), .max_i(r_q.maxsym),
        .push_o(m_push), .mark_o(m_mark), .sym_o(m_sym)
    );

    ir_rx_fifo #(.W(2*CW), .DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push_i(m_push), .wdata_i({m_mark, m_sym}),
        .pop_i(pop), .head_o(head), .count_o(count), .full_o(full), .empty_o(empty)
    );

    assign pop    = rd_en && (addr == A_SYM) && !empty;
    assign clr_wr = wr_en && (addr == A_ICLR);

    always_comb begin
        istat          = '0;
        istat[B_AVAIL] = !empty;
        istat[B_LAST]  = r_q.last;
        istat[B_OVR]   = r_q.ovr;
        istat[B_FULL]  = full;
    end

    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            case (addr)
                A_CTRL: begin
                    r_d.en  = wdata[0];
                    r_d.inv = wdata[1];
                end
                A_DIV:    r_d.div    = DIVW'(wdata);
                A_MAXSYM: r_d.maxsym = CW'(wdata);
                A_IEN:    r_d.ien    = wdata[3:0];
                default: ;
            endcase
        end
        if (clr_wr && wdata[B_LAST]) r_d.last = 1'b0;
        if (clr_wr && wdata[B_OVR])  r_d.ovr  = 1'b0;
        if (m_push && !full && m_sym == SENT) r_d.last = 1'b1;
        if (m_push && full)                   r_d.ovr  = 1'b1;
        if (pop) r_d.mark_hold = head[2*CW-1:CW];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q     <= '0;
            r_q.div <= DIVW'(1);
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            A_CTRL:   rdata = {14'd0, r_q.inv, r_q.en};
            A_DIV:    rdata = 16'(r_q.div);
            A_MAXSYM: rdata = 16'(r_q.maxsym);
            A_IEN:    rdata = {12'd0, r_q.ien};
            A_ISTAT:  rdata = {12'd0, istat};
            A_RXSTAT: begin
                rdata[15:8]  = 8'(count);
                rdata[B_OVR] = r_q.ovr;
            end
            A_MARK:   rdata = 16'(r_q.mark_hold);
            A_SYM:    rdata = 16'(head[CW-1:0]);
            default:  rdata = '0;
        endcase
    end

    assign irq = |(istat & r_q.ien);

    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.ovr && !(clr_wr && wdata[B_OVR])) |=> r_q.ovr); // R8
    AST_LAST_ON_SENTINEL: assert property (@(posedge clk) disable iff (!rst_n)
        (m_push && !full && m_sym == SENT) |=> r_q.last); // R3
    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.ien == 4'd0) |-> !irq); // R11
    AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == A_SYM && empty) |=> $stable(r_q.mark_hold)); // R7

endmodule

// File: tb/sim_ir_capture_rx.sv
module sim_ir_capture_rx;
    localparam int CLK_PERIOD = 10;

    logic        clk = 0, rst_n = 0, ir_pin = 1;
    logic        wr_en = 0, rd_en = 0;
    logic [3:0]  addr = 0;
    logic [15:0] wdata = 0;
    logic [15:0] rdata;
    logic        irq;

    int checks = 0, fails = 0;
    bit done = 0;
    bit cur_inv = 1;
    int exp_m[0:15];
    int exp_s[0:15];
    int nexp = 0;

    ir_capture_rx u0 (
        .clk(clk), .rst_n(rst_n), .ir_pin(ir_pin), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_near(input string req, input int act, input int exp);
        checks++;
        if (act < exp - 1 || act > exp + 1) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic reg_rd(input logic [3:0] a, output int v);
        @(negedge clk);
        addr = a; rd_en = 1;
        #1 v = int'(rdata);
        @(negedge clk);
        rd_en = 0;
    endtask

    function automatic logic act_lvl(input bit inv);
        return inv ? 1'b0 : 1'b1;
    endfunction

    task automatic idle_line(input int cycles);
        @(negedge clk);
        ir_pin = ~act_lvl(cur_inv);
        repeat (cycles) @(negedge clk);
    endtask

    task automatic symbol(input int m, input int s);
        @(negedge clk);
        ir_pin = act_lvl(cur_inv);
        repeat (m) @(negedge clk);
        ir_pin = ~act_lvl(cur_inv);
        repeat (s - 1) @(negedge clk);
    endtask

    task automatic configure(input bit en, input bit inv, input int div, input int mx);
        reg_wr(4'd0, 16'd0);
        cur_inv = inv;
        idle_line(4);
        reg_wr(4'd1, 16'(div));
        reg_wr(4'd2, 16'(mx));
        reg_wr(4'd0, {14'd0, inv, en});
        repeat (4) @(negedge clk);
    endtask

    task automatic drain(input string req);
        int v;
        for (int i = 0; i < nexp; i++) begin
            reg_rd(4'd8, v);
            check({req, " period"}, v, exp_s[i]);
            reg_rd(4'd7, v);
            check({req, " mark"}, v, exp_m[i]);
        end
        nexp = 0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int v, n, m, s;
        void'($urandom(32'h1234_5678));
        repeat (3) @(negedge clk);
        rst_n = 1;
        repeat (2) @(negedge clk);

        // R1 reset state
        reg_rd(4'd6, v); check("R1 rxstat", v, 0);
        reg_rd(4'd4, v); check("R1 istat", v, 0);
        check("R1 irq", int'(irq), 0);

        // R2 R4 directed: inverted line, one train
        configure(1, 1, 1, 200);
        symbol(3, 5); exp_m[0] = 3; exp_s[0] = 8;
        symbol(10, 20); exp_m[1] = 10; exp_s[1] = 30;
        symbol(4, 4); exp_m[2] = 4; exp_s[2] = 65535;
        nexp = 3;
        idle_line(230);
        reg_rd(4'd6, v); check("R9 occupancy", v >> 8, 3);
        reg_rd(4'd4, v); check("R3 last bit", (v >> 1) & 1, 1);
        check("R9 avail bit", v & 1, 1);
        drain("R2");
        reg_rd(4'd4, v); check("R9 empty avail", v & 1, 0);

        // R10 clear with zero bits keeps, with one bit clears
        reg_wr(4'd5, 16'h0001);
        reg_rd(4'd4, v); check("R10 keep last", (v >> 1) & 1, 1);
        reg_wr(4'd3, 16'h0002);
        #1 check("R11 irq last", int'(irq), 1);
        reg_wr(4'd5, 16'h0002);
        reg_rd(4'd4, v); check("R10 clear last", (v >> 1) & 1, 0);
        check("R11 irq low", int'(irq), 0);
        reg_wr(4'd3, 16'h0000);

        // R2 R4 random trains with random polarity
        for (int t = 0; t < 6; t++) begin
            configure(1, 1'($urandom_range(0, 1)), 1, 200);
            n = $urandom_range(1, 7);
            for (int k = 0; k < n; k++) begin
                m = $urandom_range(3, 40);
                s = $urandom_range(3, 50);
                symbol(m, s);
                exp_m[k] = m;
                exp_s[k] = (k == n - 1) ? 65535 : m + s;
            end
            nexp = n;
            idle_line(230);
            reg_rd(4'd6, v); check("R4 occupancy", v >> 8, n);
            drain("R4");
            reg_wr(4'd5, 16'h0006);
        end

        // R5 disabled: no entries
        configure(0, 1, 1, 200);
        symbol(5, 10); symbol(5, 10);
        idle_line(50);
        reg_rd(4'd6, v); check("R5 no entries", v >> 8, 0);
        reg_rd(4'd4, v); check("R5 no status", v, 0);

        // R6 divisor of 4
        configure(1, 1, 4, 200);
        symbol(40, 60);
        idle_line(1000);
        reg_rd(4'd8, v); check("R6 sentinel", v, 65535);
        reg_rd(4'd7, v); check_near("R6 mark ticks", v, 10);
        reg_wr(4'd5, 16'h0006);

        // R6 second entry in ticks
        configure(1, 1, 4, 200);
        symbol(40, 60); symbol(20, 20);
        idle_line(1000);
        reg_rd(4'd8, v); check_near("R6 period ticks", v, 25);
        reg_rd(4'd7, v); check_near("R6 mark ticks 2", v, 10);
        reg_rd(4'd8, v); check("R6 close", v, 65535);
        reg_wr(4'd5, 16'h0006);

        // R8 R9 overrun
        configure(1, 1, 1, 200);
        reg_wr(4'd3, 16'h0004);
        for (int k = 0; k < 10; k++) symbol(5, 10);
        idle_line(250);
        reg_rd(4'd6, v);
        check("R9 full occupancy", v >> 8, 8);
        check("R8 rx overflow bit", (v >> 2) & 1, 1);
        reg_rd(4'd4, v);
        check("R9 full bit", (v >> 3) & 1, 1);
        check("R8 ovr bit", (v >> 2) & 1, 1);
        check("R8 last dropped", (v >> 1) & 1, 0);
        check("R11 irq ovr", int'(irq), 1);
        reg_wr(4'd5, 16'h0004);
        reg_rd(4'd4, v); check("R10 ovr cleared", (v >> 2) & 1, 0);
        check("R11 irq after clear", int'(irq), 0);
        for (int k = 0; k < 8; k++) begin exp_m[k] = 5; exp_s[k] = 15; end
        nexp = 8;
        drain("R7");
        reg_wr(4'd3, 16'h0000);

        // R12 saturation of mark counter
        configure(1, 1, 1, 100);
        @(negedge clk); ir_pin = act_lvl(cur_inv);
        repeat (66000) @(negedge clk);
        idle_line(200);
        reg_rd(4'd8, v); check("R12 period sat", v, 65535);
        reg_rd(4'd7, v); check("R12 mark sat", v, 65535);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule